// File: doc/BRIEF.md
# Folded Squarer with Difference-of-Squares Product Mode

This block is purely combinational. In square mode it returns the square of a K-bit unsigned operand. Before any addition it folds the partial-product matrix of a·a. A self-product bit a_i·a_i is just a_i. A mirrored pair a_i·a_j plus a_j·a_i becomes one bit that sits one column higher. Each diagonal bit is also merged with the adjacent-pair bit that lands in the same column, so that column loses another entry. The result is a matrix of roughly half the original height, which is then summed.

In product mode the same hardware forms a·x from two squares. A (K+1)-bit sum a+x and the magnitude |a−x| each drive their own folded squarer. The two squares are subtracted, and the difference is shifted right by two. Both results are 2K bits wide. There is no clock and no state: the output follows the inputs.

Top module: `sqr_dual_unit`

## Requirements
- R1: With `mode` = 0 (square), `result` equals a·a for every K-bit unsigned `a`.
- R2: With `mode` = 0, bit 0 of `result` always equals bit 0 of `a`.
- R3: With `mode` = 0, bit 1 of `result` is always 0.
- R4: With `mode` = 1 (product), `result` equals a·x for every pair of K-bit unsigned operands.
- R5: With `mode` = 1, swapping `a` and `x` leaves `result` unchanged.
- R6: When `a` equals `x`, the product-mode result equals the square-mode result for that `a`.
- R7: With `mode` = 1, a zero in either operand gives a `result` of 0.
- R8: With `mode` = 0, the value on `x` has no effect on `result`.
- R9: All-ones operands give (2^K−1)^2 = 2^(2K) − 2^(K+1) + 1 in both modes, with no loss of upper bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | K | First unsigned operand; the value squared in square mode |
| x | input | K | Second unsigned operand; used only in product mode |
| mode | input | 1 | 0 = square of `a`, 1 = product a·x |
| result | output | 2K | Square or product, unsigned |

## Verification
For K = 6, every value of `a` is squared, with a random-looking `x` alongside it. This exposes any misplaced folded bit, since each row contributes to a distinct set of input patterns. The checks on bits 0 and 1 separate a wrong diagonal term from a wrong merged term. All 4096 operand pairs are run in product mode, which catches a truncated sum or a wrong sign in the magnitude. Swapped operand pairs and equal operands are also run: equal operands drive the difference path to zero, and swapped operands flip which side of |a−x| is taken. Finally, a sweep of `x` at fixed `a` in square mode, together with zero and all-ones operands, covers input leakage and the top carry.

// File: rtl/sqr_pkg.sv
// Shared definitions for the folded squarer family.
// Assumes: mode encoding is a single bit, square = 0, product = 1.
package sqr_pkg;

    typedef enum logic {
        SQ_MODE_SQUARE  = 1'b0,
        SQ_MODE_PRODUCT = 1'b1
    } sq_mode_e;

endpackage

// File: rtl/sqr_fold_rows.sv
// Builds the folded partial-product matrix of op*op as N rows of 2N bits.
// Row i holds: the merged diagonal bit op[i]&~op[i-1] at column 2i, the
// adjacent pair bit op[i-1]&op[i] at column 2i+1, and the pair bits
// op[i]&op[j] (j >= i+2) at column i+j+1. The rows add up to op*op.
// Assumes: op is unsigned; N >= 2.
module sqr_fold_rows #(
    parameter int N = 7,
    localparam int W = 2 * N
) (
    input  logic [N-1:0]        op,
    output logic [N-1:0][W-1:0] rows
);

    for (genvar gi = 0; gi < N; gi++) begin : g_row
        if (gi == 0) begin : g_first
            // Row 0: lone diagonal bit; its adjacent pair lives in row 1
            always_comb begin
                rows[gi] = '0;
                rows[gi][0] = op[0];
                for (int j = 2; j < N; j++) begin
                    rows[gi][j + 1] = op[0] & op[j];
                end
            end
        end else begin : g_rest
            // Row i: merged diagonal, adjacent pair, then distant pairs
            always_comb begin
                rows[gi] = '0;
                rows[gi][2 * gi]     = op[gi] & ~op[gi - 1];
                rows[gi][2 * gi + 1] = op[gi] & op[gi - 1];
                for (int j = gi + 2; j < N; j++) begin
                    rows[gi][gi + j + 1] = op[gi] & op[j];
                end
            end
        end
    end

endmodule

// File: rtl/sqr_row_sum.sv
// Adds the N folded rows into a single 2N-bit square.
// Assumes: the rows' true sum fits 2N bits (it is a square of N bits).
module sqr_row_sum #(
    parameter int N = 7,
    localparam int W = 2 * N
) (
    input  logic [N-1:0][W-1:0] rows,
    output logic [W-1:0]        total
);

    // Accumulate the rows; synthesis is free to rebalance into a tree
    always_comb begin
        total = '0;
        for (int i = 0; i < N; i++) begin
            total = total + rows[i];
        end
    end

endmodule

// File: rtl/sqr_fold_squarer.sv
// One folded squarer: matrix generation followed by row summation.
// Assumes: unsigned N-bit input; output is the exact 2N-bit square.
module sqr_fold_squarer #(
    parameter int N = 7,
    localparam int W = 2 * N
) (
    input  logic [N-1:0] op,
    output logic [W-1:0] sq
);

    logic [N-1:0][W-1:0] rows;

    sqr_fold_rows #(.N(N)) u_rows (
        .op   (op),
        .rows (rows)
    );

    sqr_row_sum #(.N(N)) u_sum (
        .rows  (rows),
        .total (sq)
    );

endmodule

// File: rtl/sqr_dual_unit.sv
// Top: square of a, or product a*x formed as ((a+x)^2 - |a-x|^2) / 4.
// Two folded squarers of K+1 bits are shared between the modes: the upper
// one squares a (square mode) or a+x (product mode), the lower one squares
// |a-x|. Purely combinational.
// Assumes: unsigned operands; mode 0 = square, 1 = product.
module sqr_dual_unit
    import sqr_pkg::*;
#(
    parameter int K = 6,
    localparam int N  = K + 1,
    localparam int WS = 2 * N,
    localparam int WR = 2 * K
) (
    input  logic [K-1:0]  a,
    input  logic [K-1:0]  x,
    input  logic          mode,
    output logic [WR-1:0] result
);

    logic [N-1:0]  sum_ax;
    logic [K-1:0]  mag_ax;
    logic [N-1:0]  in_p;
    logic [N-1:0]  in_m;
    logic [WS-1:0] sq_p;
    logic [WS-1:0] sq_m;
    logic [WS-1:0] dif;

    // Operand conditioning: widened sum and magnitude of the difference
    always_comb begin
        sum_ax = {1'b0, a} + {1'b0, x};
        mag_ax = (a >= x) ? (a - x) : (x - a);
        in_p   = (mode == SQ_MODE_PRODUCT) ? sum_ax : {1'b0, a};
        in_m   = {1'b0, mag_ax};
    end

    sqr_fold_squarer #(.N(N)) u_sq_p (
        .op (in_p),
        .sq (sq_p)
    );

    sqr_fold_squarer #(.N(N)) u_sq_m (
        .op (in_m),
        .sq (sq_m)
    );

    // Output select: quarter of the square difference, or the plain square
    always_comb begin
        dif    = sq_p - sq_m;
        result = (mode == SQ_MODE_PRODUCT) ? dif[WR+1:2] : sq_p[WR-1:0];
    end

endmodule

// File: rtl/sqr_dual_unit_chk.sv
// Checker for sqr_dual_unit, attached by bind. Uses immediate assertions
// because the unit has no clock; each is evaluated after its inputs settle.
module sqr_dual_unit_chk #(
    parameter int K = 6,
    localparam int N  = K + 1,
    localparam int WS = 2 * N,
    localparam int WR = 2 * K
) (
    input logic [K-1:0]  a,
    input logic [K-1:0]  x,
    input logic          mode,
    input logic [WR-1:0] result,
    input logic [WS-1:0] sq_p,
    input logic [WS-1:0] sq_m
);

    logic [WS-1:0] gap;

    // Cross-instance properties of the two squarers and the output
    always_comb begin
        gap = sq_p - sq_m;
        if (mode == 1'b0) begin
            AST_SQ_LSB: assert (result[0] == a[0]);              // R2
            AST_SQ_BIT1_ZERO: assert (result[1] == 1'b0);        // R3
        end else begin
            AST_DIFF_LOW_ZERO: assert (gap[1:0] == 2'b00);       // R4
            AST_SUM_SQ_DOMINATES: assert (sq_p >= sq_m);         // R4
            if (a == '0 || x == '0) begin
                AST_ZERO_OPERAND: assert (result == '0);         // R7
            end
            if (a == x) begin
                AST_EQUAL_OPERANDS: assert (sq_m == '0);         // R6
            end
        end
    end

endmodule

bind sqr_dual_unit sqr_dual_unit_chk #(.K(K)) u_chk (
    .a      (a),
    .x      (x),
    .mode   (mode),
    .result (result),
    .sq_p   (sq_p),
    .sq_m   (sq_m)
);

// File: tb/sqr_dual_unit_bench.sv
// Self-checking bench: vector table, exhaustive sweeps, directed corners.
module sqr_dual_unit_bench;

    localparam int K    = 6;
    localparam int WR   = 2 * K;
    localparam int TOP  = (1 << K) - 1;
    localparam int NVEC = 8;

    // Table columns: a, x, mode, expected result
    localparam int VA [NVEC] = '{0, 63, 63, 63, 1, 0, 5, 37};
    localparam int VX [NVEC] = '{63, 0, 63, 1, 63, 45, 0, 22};
    localparam int VM [NVEC] = '{0, 0, 1, 1, 1, 1, 0, 1};
    localparam int VE [NVEC] = '{0, 3969, 3969, 63, 63, 0, 25, 814};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [K-1:0]  a = '0;
    logic [K-1:0]  x = '0;
    logic          mode = 1'b0;
    logic [WR-1:0] result;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    sqr_dual_unit #(.K(K)) u_sqr_dual_unit (
        .a      (a),
        .x      (x),
        .mode   (mode),
        .result (result)
    );

    always #4 clk = ~clk;

    // Watchdog: a hung run is a failed check and still reports
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 50000) begin
            errors = errors + 1;
            $display("FAIL watchdog: cycles %0d expected below %0d", cycles, 50000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string tag, input int got, input int exp);
        checks = checks + 1;
        if (got != exp) begin
            errors = errors + 1;
            $display("FAIL %s: a=%0d x=%0d mode=%0d got %0d expected %0d",
                     tag, a, x, mode, got, exp);
        end
    endtask

    task automatic apply(input int va, input int vx, input int vm);
        @(negedge clk);
        a    = K'(va);
        x    = K'(vx);
        mode = vm[0];
        #2;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        check("R1 idle zero", int'(result), 0);

        for (int v = 0; v < NVEC; v++) begin
            apply(VA[v], VX[v], VM[v]);
            check("table vector", int'(result), VE[v]);
        end

        for (int ia = 0; ia <= TOP; ia++) begin
            apply(ia, (ia * 37 + 11) & TOP, 0);
            check("R1 square", int'(result), ia * ia);
            check("R2 lsb", int'(result[0]), ia & 1);
            check("R3 bit1", int'(result[1]), 0);
        end

        for (int ia = 0; ia <= TOP; ia++) begin
            for (int ix = 0; ix <= TOP; ix++) begin
                apply(ia, ix, 1);
                check("R4 product", int'(result), ia * ix);
            end
        end

        for (int ia = 0; ia <= TOP; ia += 7) begin
            for (int ix = 0; ix <= TOP; ix += 5) begin
                int fwd;
                apply(ia, ix, 1);
                fwd = int'(result);
                apply(ix, ia, 1);
                check("R5 swapped", int'(result), fwd);
            end
        end

        for (int ia = 0; ia <= TOP; ia += 3) begin
            int sq0;
            apply(ia, ia, 0);
            sq0 = int'(result);
            apply(ia, ia, 1);
            check("R6 equal operands", int'(result), sq0);
        end

        for (int ia = 0; ia <= TOP; ia += 9) begin
            apply(ia, 0, 1);
            check("R7 x zero", int'(result), 0);
            apply(0, ia, 1);
            check("R7 a zero", int'(result), 0);
        end

        for (int ix = 0; ix <= TOP; ix++) begin
            apply(45, ix, 0);
            check("R8 x ignored", int'(result), 2025);
        end

        apply(TOP, 0, 0);
        check("R9 max square", int'(result), (1 << WR) - (1 << (K + 1)) + 1);
        apply(TOP, TOP, 1);
        check("R9 max product", int'(result), (1 << WR) - (1 << (K + 1)) + 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule